// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the sharing record for one memory line in a directory-based coherence scheme. The record holds a fixed number of pointer slots, and each slot names one caching processor by its processor number. The record has no per-processor bit vector, so its width grows with the logarithm of the processor count. The number of processors may be larger than the number of slots. A compile-time parameter then sets what happens when a new reader arrives and every slot is already in use. Under the evicting policy, one listed reader is invalidated and its slot is given to the newcomer. Under the broadcast policy, a broadcast flag is raised instead, and the next write invalidates every processor.

The surrounding controller presents one operation per cycle. The operation is an add of a reader, a drop of a reader, or a write that gains ownership. The block answers with a registered invalidation pulse that carries a per-processor target mask and a broadcast indication. It also exposes the current slot contents, the broadcast flag and the dirty flag. Message transport and line data are handled elsewhere.

Top module: `lp_dir_entry`

## Requirements
- R1: After reset all slots are invalid, the broadcast flag and dirty flag are 0, and no invalidation is signalled.
- R2: Adding a processor that is not listed, while some slot is free, writes it into the lowest-numbered free slot. The new entry is visible the cycle after the operation.
- R3: Adding a processor that is already listed leaves slots, flags and the eviction index unchanged and signals no invalidation.
- R4: With the evicting policy (OVF_BCAST=0), adding an unlisted processor to a full entry invalidates the processor in the slot picked by a round-robin index. The invalidation is a mask with exactly that processor's bit set, and the newcomer takes that slot. The index starts at 0 after reset and after every write, and advances by one modulo the slot count after each eviction.
- R5: With the broadcast policy (OVF_BCAST=1), adding an unlisted processor to a full entry sets the broadcast flag, leaves the slots unchanged and signals no invalidation. With the evicting policy the broadcast flag is never set.
- R6: A write with the broadcast flag clear invalidates exactly the listed processors other than the writer (mask bit p = processor p). The invalidation pulse is raised only when that mask is non-zero.
- R7: A write with the broadcast flag set raises the broadcast indication and a mask holding every processor except the writer.
- R8: After a write, slot 0 holds the writer and is the only valid slot, the broadcast flag is clear and the dirty flag is set.
- R9: Dropping a listed processor invalidates its slot, and dropping the owner clears the dirty flag. Dropping an unlisted processor changes nothing.
- R10: While the dirty flag is set exactly one slot is valid. Adding a new reader clears the dirty flag and keeps the former owner listed.
- R11: The invalidation pulse lasts one cycle, follows only an operation in the previous cycle, and the mask is zero whenever the pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 none, 1 add reader, 2 drop reader, 3 write |
| op_pid | input | PIDW | Processor number of the operation |
| slot_vld_o | output | NPTR | Valid bit of each slot |
| slot_pid_o | output | NPTR*PIDW | Processor number of each slot, slot 0 in the low bits |
| bcast_o | output | 1 | Broadcast flag |
| dirty_o | output | 1 | Dirty flag, owner in slot 0 |
| inv_valid_o | output | 1 | Invalidation pulse |
| inv_bcast_o | output | 1 | Invalidation goes to all processors |
| inv_mask_o | output | NPROC | Invalidation targets, bit p = processor p |

## Verification
Every result is registered once, so the slots, the flags and the invalidation pulse all reflect an operation on the cycle after the clock edge that sampled it. The bench drives an operation on a falling edge and checks the outputs on the following falling edge. That point lies after the one capturing edge and before the next one, so the one-cycle pulse is still visible there. The evicting and broadcast instances receive the same operations and are compared against a reference model in the bench that is written from the requirements.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ADD   = 2'd1,
    OP_DROP  = 2'd2,
    OP_WRITE = 2'd3
  } lpd_op_e;
endpackage

// File: rtl/lpd_match.sv
module lpd_match #(
  parameter int NPTR = 4,
  parameter int PIDW = 4
) (
  input  logic [NPTR-1:0]      vld,
  input  logic [NPTR*PIDW-1:0] pids,
  input  logic [PIDW-1:0]      key,
  output logic [NPTR-1:0]      hit_vec,
  output logic                 hit_any,
  output logic                 full
);
  for (genvar s = 0; s < NPTR; s++) begin : g_cmp
    assign hit_vec[s] = vld[s] && (pids[s*PIDW +: PIDW] == key);
  end
  assign hit_any = |hit_vec;
  assign full    = &vld;
endmodule

// File: rtl/lpd_pick.sv
module lpd_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] free_vec,
  output logic [W-1:0] idx
);
  function automatic logic [W-1:0] lowest_set(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = W'(i);
    end
    return r;
  endfunction
  assign idx = lowest_set(free_vec);
endmodule

// File: rtl/lpd_inv_build.sv
module lpd_inv_build #(
  parameter int NPROC = 16,
  parameter int NPTR  = 4,
  parameter int PIDW  = 4
) (
  input  logic [NPTR-1:0]      vld,
  input  logic [NPTR*PIDW-1:0] pids,
  input  logic                 bcast,
  input  logic [PIDW-1:0]      writer,
  output logic [NPROC-1:0]     mask
);
  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    logic [NPTR-1:0] at_slot;
    for (genvar s = 0; s < NPTR; s++) begin : g_slot
      assign at_slot[s] = vld[s] && (pids[s*PIDW +: PIDW] == PIDW'(p));
    end
    assign mask[p] = (bcast || (|at_slot)) && (writer != PIDW'(p));
  end
endmodule

// File: rtl/lp_dir_entry.sv
module lp_dir_entry
  import lpd_pkg::*;
#(
  parameter int NPROC     = 16,
  parameter int NPTR      = 4,
  parameter bit OVF_BCAST = 1'b0,
  parameter int PIDW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [1:0]           op_kind,
  input  logic [PIDW-1:0]      op_pid,
  output logic [NPTR-1:0]      slot_vld_o,
  output logic [NPTR*PIDW-1:0] slot_pid_o,
  output logic                 bcast_o,
  output logic                 dirty_o,
  output logic                 inv_valid_o,
  output logic                 inv_bcast_o,
  output logic [NPROC-1:0]     inv_mask_o
);
  localparam int IDXW = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [NPTR-1:0]      vld_q, vld_d;
  logic [NPTR*PIDW-1:0] pid_q, pid_d;
  logic                 bcast_q, bcast_d;
  logic                 dirty_q, dirty_d;
  logic [IDXW-1:0]      rr_q, rr_d;
  logic                 inv_v_q, inv_v_d;
  logic                 inv_b_q, inv_b_d;
  logic [NPROC-1:0]     inv_m_q, inv_m_d;

  lpd_op_e         kind;
  logic            op_fire, is_add, is_drop, is_write;
  logic [NPTR-1:0] hit_vec;
  logic            hit_any, full;
  logic [IDXW-1:0] free_idx;
  logic [NPROC-1:0] write_mask;
  logic [PIDW-1:0] victim_pid;

  // named events for the checks
  logic add_hit_ev, evict_ev, ovf_bcast_ev;

  assign kind     = lpd_op_e'(op_kind);
  assign op_fire  = op_valid && (kind != OP_NONE);
  assign is_add   = op_valid && (kind == OP_ADD);
  assign is_drop  = op_valid && (kind == OP_DROP);
  assign is_write = op_valid && (kind == OP_WRITE);

  lpd_match #(.NPTR(NPTR), .PIDW(PIDW)) u_match (
    .vld(vld_q), .pids(pid_q), .key(op_pid),
    .hit_vec(hit_vec), .hit_any(hit_any), .full(full)
  );

  lpd_pick #(.N(NPTR), .W(IDXW)) u_pick (
    .free_vec(~vld_q), .idx(free_idx)
  );

  lpd_inv_build #(.NPROC(NPROC), .NPTR(NPTR), .PIDW(PIDW)) u_inv (
    .vld(vld_q), .pids(pid_q), .bcast(bcast_q), .writer(op_pid),
    .mask(write_mask)
  );

  assign add_hit_ev   = is_add && hit_any;
  assign evict_ev     = is_add && !hit_any && full && !OVF_BCAST;
  assign ovf_bcast_ev = is_add && !hit_any && full && OVF_BCAST;
  assign victim_pid   = pid_q[rr_q*PIDW +: PIDW];

  function automatic logic [IDXW-1:0] rr_next(input logic [IDXW-1:0] cur);
    return (int'(cur) == NPTR - 1) ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    vld_d   = vld_q;
    pid_d   = pid_q;
    bcast_d = bcast_q;
    dirty_d = dirty_q;
    rr_d    = rr_q;
    inv_v_d = 1'b0;
    inv_b_d = 1'b0;
    inv_m_d = '0;
    if (is_add && !hit_any) begin
      dirty_d = 1'b0;
      if (!full) begin
        vld_d[free_idx] = 1'b1;
        pid_d[free_idx*PIDW +: PIDW] = op_pid;
      end else if (evict_ev) begin
        pid_d[rr_q*PIDW +: PIDW] = op_pid;
        rr_d    = rr_next(rr_q);
        inv_v_d = 1'b1;
        inv_m_d = NPROC'(1) << victim_pid;
      end else begin
        bcast_d = 1'b1;
      end
    end else if (is_drop && hit_any) begin
      vld_d   = vld_q & ~hit_vec;
      dirty_d = 1'b0;
    end else if (is_write) begin
      inv_m_d = write_mask;
      inv_v_d = |write_mask;
      inv_b_d = bcast_q;
      vld_d   = NPTR'(1);
      pid_d   = '0;
      pid_d[PIDW-1:0] = op_pid;
      bcast_d = 1'b0;
      dirty_d = 1'b1;
      rr_d    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      pid_q   <= '0;
      bcast_q <= 1'b0;
      dirty_q <= 1'b0;
      rr_q    <= '0;
      inv_v_q <= 1'b0;
      inv_b_q <= 1'b0;
      inv_m_q <= '0;
    end else begin
      vld_q   <= vld_d;
      pid_q   <= pid_d;
      bcast_q <= bcast_d;
      dirty_q <= dirty_d;
      rr_q    <= rr_d;
      inv_v_q <= inv_v_d;
      inv_b_q <= inv_b_d;
      inv_m_q <= inv_m_d;
    end
  end

  assign slot_vld_o  = vld_q;
  assign slot_pid_o  = pid_q;
  assign bcast_o     = bcast_q;
  assign dirty_o     = dirty_q;
  assign inv_valid_o = inv_v_q;
  assign inv_bcast_o = inv_b_q;
  assign inv_mask_o  = inv_m_q;

  p_dup_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_hit_ev |=> ($stable(vld_q) && $stable(pid_q) && $stable(rr_q) && !inv_v_q));

  p_evict_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ev |=> (inv_v_q && !inv_b_q && $countones(inv_m_q) == 1));

  p_bcast_policy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!OVF_BCAST) |-> !bcast_q);

  p_ovf_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_bcast_ev |=> (bcast_q && $stable(vld_q) && !inv_v_q));

  p_write_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |=> (dirty_q && vld_q == NPTR'(1) && !bcast_q
                  && pid_q[PIDW-1:0] == $past(op_pid) && rr_q == '0));

  p_dirty_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_q |-> ($countones(vld_q) == 1));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_fire |=> !inv_v_q);

  p_mask_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_v_q |-> (inv_m_q == '0 && !inv_b_q));
endmodule

// File: tb/lp_dir_entry_tb_top.sv
module lp_dir_entry_tb_top;
  localparam int NPROC = 16;
  localparam int NPTR  = 4;
  localparam int PIDW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [PIDW-1:0] op_pid = '0;

  logic [NPTR-1:0]      vld_o [2];
  logic [NPTR*PIDW-1:0] pid_o [2];
  logic                 bc_o  [2];
  logic                 dt_o  [2];
  logic                 iv_o  [2];
  logic                 ib_o  [2];
  logic [NPROC-1:0]     im_o  [2];

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lp_dir_entry #(.NPROC(NPROC), .NPTR(NPTR), .OVF_BCAST(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_pid(op_pid),
    .slot_vld_o(vld_o[0]), .slot_pid_o(pid_o[0]), .bcast_o(bc_o[0]), .dirty_o(dt_o[0]),
    .inv_valid_o(iv_o[0]), .inv_bcast_o(ib_o[0]), .inv_mask_o(im_o[0])
  );

  lp_dir_entry #(.NPROC(NPROC), .NPTR(NPTR), .OVF_BCAST(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_pid(op_pid),
    .slot_vld_o(vld_o[1]), .slot_pid_o(pid_o[1]), .bcast_o(bc_o[1]), .dirty_o(dt_o[1]),
    .inv_valid_o(iv_o[1]), .inv_bcast_o(ib_o[1]), .inv_mask_o(im_o[1])
  );

  // reference model, index 0 = evicting, 1 = broadcast
  bit        m_v  [2][NPTR];
  int        m_p  [2][NPTR];
  bit        m_bc [2];
  bit        m_dt [2];
  int        m_rr [2];
  bit        m_iv [2];
  bit        m_ib [2];
  bit [NPROC-1:0] m_im [2];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < NPTR; s++) begin m_v[k][s] = 0; m_p[k][s] = 0; end
      m_bc[k] = 0; m_dt[k] = 0; m_rr[k] = 0;
      m_iv[k] = 0; m_ib[k] = 0; m_im[k] = '0;
    end
  endtask

  task automatic model_op(input int kind, input int pid);
    for (int k = 0; k < 2; k++) begin
      int where;
      int used;
      m_iv[k] = 0; m_ib[k] = 0; m_im[k] = '0;
      where = -1; used = 0;
      for (int s = 0; s < NPTR; s++) begin
        if (m_v[k][s]) used++;
        if (m_v[k][s] && m_p[k][s] == pid) where = s;
      end
      if (kind == 1 && where < 0) begin
        m_dt[k] = 0;
        if (used < NPTR) begin
          for (int s = 0; s < NPTR; s++)
            if (!m_v[k][s] && where < 0) begin m_v[k][s] = 1; m_p[k][s] = pid; where = s; end
        end else if (k == 0) begin
          m_iv[k] = 1;
          m_im[k][m_p[k][m_rr[k]]] = 1'b1;
          m_p[k][m_rr[k]] = pid;
          m_rr[k] = (m_rr[k] + 1) % NPTR;
        end else begin
          m_bc[k] = 1;
        end
      end else if (kind == 2 && where >= 0) begin
        m_v[k][where] = 0;
        m_dt[k] = 0;
      end else if (kind == 3) begin
        for (int p = 0; p < NPROC; p++) begin
          bit listed;
          listed = m_bc[k];
          for (int s = 0; s < NPTR; s++) if (m_v[k][s] && m_p[k][s] == p) listed = 1;
          if (listed && p != pid) m_im[k][p] = 1'b1;
        end
        m_iv[k] = (m_im[k] != '0);
        m_ib[k] = m_bc[k];
        for (int s = 0; s < NPTR; s++) begin m_v[k][s] = (s == 0); m_p[k][s] = 0; end
        m_p[k][0] = pid;
        m_bc[k] = 0; m_dt[k] = 1; m_rr[k] = 0;
      end
    end
  endtask

  task automatic compare(input string req);
    for (int k = 0; k < 2; k++) begin
      bit [NPTR-1:0] ev;
      for (int s = 0; s < NPTR; s++) begin
        ev[s] = m_v[k][s];
        if (m_v[k][s]) check(req, $sformatf("dut%0d slot%0d pid", k, s),
                             int'(pid_o[k][s*PIDW +: PIDW]), m_p[k][s]);
      end
      check(req, $sformatf("dut%0d slot valid", k), int'(vld_o[k]), int'(ev));
      check(req, $sformatf("dut%0d bcast flag", k), int'(bc_o[k]), int'(m_bc[k]));
      check(req, $sformatf("dut%0d dirty", k), int'(dt_o[k]), int'(m_dt[k]));
      check(req, $sformatf("dut%0d inv valid", k), int'(iv_o[k]), int'(m_iv[k]));
      check(req, $sformatf("dut%0d inv bcast", k), int'(ib_o[k]), int'(m_ib[k]));
      check(req, $sformatf("dut%0d inv mask", k), int'(im_o[k]), int'(m_im[k]));
    end
  endtask

  // drive on a falling edge, result due after the next rising edge
  task automatic do_op(input int kind, input int pid, input string req);
    @(negedge clk);
    op_valid = (kind != 0);
    op_kind  = 2'(kind);
    op_pid   = PIDW'(pid);
    model_op(kind, pid);
    @(negedge clk);
    op_valid = 1'b0;
    op_kind  = 2'd0;
    compare(req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    check("R1", "evict slots empty", int'(vld_o[0]), 0);
    check("R1", "bcast slots empty", int'(vld_o[1]), 0);
  endtask

  task automatic t_fill();
    do_op(1, 3, "R2");
    do_op(1, 7, "R2");
    do_op(1, 9, "R2");
    check("R2", "third reader in slot2", int'(pid_o[0][2*PIDW +: PIDW]), 9);
    do_op(1, 7, "R3");
    check("R3", "duplicate add no pulse", int'(iv_o[0]), 0);
    do_op(1, 12, "R2");
  endtask

  task automatic t_overflow();
    do_op(1, 5, "R4/R5");
    check("R4", "first victim is pid 3", int'(im_o[0]), 1 << 3);
    check("R4", "newcomer in slot0", int'(pid_o[0][0 +: PIDW]), 5);
    check("R5", "bcast flag raised", int'(bc_o[1]), 1);
    do_op(1, 6, "R4/R5");
    check("R4", "second victim is pid 7", int'(im_o[0]), 1 << 7);
    do_op(1, 5, "R3");
  endtask

  task automatic t_drop();
    do_op(2, 9, "R9");
    check("R9", "slot2 cleared", int'(vld_o[0][2]), 0);
    do_op(2, 14, "R9");
    do_op(1, 14, "R2");
    check("R2", "refill lowest free slot", int'(pid_o[0][2*PIDW +: PIDW]), 14);
  endtask

  task automatic t_write();
    do_op(3, 12, "R6/R7/R8");
    check("R6", "listed minus writer", int'(im_o[0]), (1 << 5) | (1 << 6) | (1 << 14));
    check("R7", "all but writer", int'(im_o[1]), 16'hFFFF & ~(1 << 12));
    check("R7", "bcast indication", int'(ib_o[1]), 1);
    check("R8", "bcast flag cleared", int'(bc_o[1]), 0);
    do_op(0, 0, "R11");
    check("R11", "pulse gone after idle", int'(iv_o[1]), 0);
    do_op(3, 12, "R6");
    check("R6", "owner rewrite no pulse", int'(iv_o[0]), 0);
  endtask

  task automatic t_dirty();
    do_op(1, 4, "R10");
    check("R10", "dirty cleared by reader", int'(dt_o[0]), 0);
    check("R10", "owner kept", int'(pid_o[0][0 +: PIDW]), 12);
    do_op(3, 4, "R8");
    check("R8", "single owner", int'(vld_o[1]), 1);
    do_op(2, 4, "R9");
    check("R9", "owner drop clears dirty", int'(dt_o[0]), 0);
    // refill and rotate the eviction index past a write
    do_op(1, 1, "R2");
    do_op(1, 2, "R2");
    do_op(1, 3, "R2");
    do_op(1, 8, "R2");
    do_op(1, 10, "R4");
    check("R4", "index restarts at 0 after write", int'(im_o[0]), 1 << 1);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_overflow();
    t_drop();
    t_write();
    t_dirty();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule